// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

The block moves characters between a parallel register interface and a pair of asynchronous serial lines. A processor writes a byte to the data register to start a transmission. It reads the same address to collect a received character. A status register reports whether a received character is waiting, whether the transmitter is free, and whether the last character had a parity, framing or overrun error. A mode register sets the character length (5 to 8 bits), turns parity on or off, chooses even or odd parity, and sets the transmitted stop length to 1, 1.5 or 2 bit times.

The bit clock comes from an internal counter that divides the system clock by `div_i + 1`. Each pulse of that counter is one sixteenth of a bit time. The receiver takes the falling edge of the start bit as its time reference. It checks half a bit later that the line is still low, then samples every data bit, the parity bit and the first stop bit at the centre of that bit. There are two level interrupt outputs. One shows that a received character is waiting. The other shows that the transmitter has finished its character and is idle.

Top module: `sio_core`

## Requirements
- R1: After reset, status reads 0x02 (only transmit-empty set), the data register reads 0x00, `txd_o` is high, `irq_rx_o` is low and `irq_tx_o` is high.
- R2: A transmitted frame is one low start bit, then N = 5 + mode[1:0] data bits least significant bit first, then an optional parity bit, then a high stop level. Each bit lasts 16 baud ticks, and a tick comes every `div_i + 1` clocks.
- R3: Transmit-empty (status bit 1, `irq_tx_o`) goes low on the data write. It rises once the stop time has elapsed, 16 × (1 + N + P) + S ticks after the start bit began. P is 1 when parity is on. S is 16, 24 or 32 for mode[5:4] = 0, 1 or 2 (3 behaves as 2).
- R4: With mode[2] set, the parity bit makes the count of ones over the data and parity bits even when mode[3] = 0 and odd when mode[3] = 1.
- R5: A data-register write while transmit-empty is low is ignored. The frame in flight is unchanged and no second frame follows.
- R6: The receiver samples each bit at its centre and presents the N received bits, zero-extended, in the data register (address 0). It sets receive-ready (status bit 0, `irq_rx_o`) at the centre of the stop bit.
- R7: Parity error (status bit 2) is set with a received character when parity is on and the received parity bit does not match the mode's sense.
- R8: Framing error (status bit 3) is set with a received character whose first stop bit is sampled low.
- R9: A low pulse on `rxd_i` that has ended by half a bit time after its falling edge is discarded. No character is reported and the receiver accepts the next frame normally.
- R10: If a character completes while receive-ready is still set, overrun (status bit 4) is set and the data register holds the newer character.
- R11: A read of the data register clears receive-ready, parity error, framing error and overrun. `irq_rx_o` then goes low.
- R12: The mode register at address 2 reads back the byte last written to it. Address 1 is status, with bits 7..5 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Baud tick divisor; one tick every div_i+1 clocks |
| sel_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 data, 1 status, 2 mode |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| irq_rx_o | output | 1 | Received character waiting |
| irq_tx_o | output | 1 | Transmitter idle after finishing a character |

## Verification
The transmit line goes low on the clock edge that takes the data write. Every later bit boundary falls on a baud tick that arrives 1 to div_i+1 clocks after that edge. The bench therefore takes the observed falling edge as its origin and samples each bit 32 clocks into its 64-clock slot (div_i = 3). It checks that transmit-empty is still low 5 clocks before the nominal frame end and high 1 clock after it, which brackets the tick jitter. On the receive side, the character completes about 30 to 34 clocks into the stop bit, after a two-flop synchronizer and tick alignment. The bench waits out the whole stop bit and 16 further clocks before it reads status, so every receive result is settled when it is checked. Register reads are sampled 1 ns after the strobe is driven at a falling edge. The effects of a read (cleared flags, low `irq_rx_o`) are checked from the next falling edge on.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic [1:0] stop;    // 0: 1 bit, 1: 1.5 bits, 2/3: 2 bits
    logic       odd;
    logic       par_en;
    logic [1:0] len;     // data bits = 5 + len
  } mode_t;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;

  function automatic logic [2:0] last_bit(logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  function automatic logic [7:0] len_mask(logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic par_of(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  mode_t      mode_i,
  output logic       idle_o,
  output logic       txd_o
);
  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_M1  = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP1   = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP15  = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] STOP2   = CW'(2 * OVS - 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q, stop_last_q;
  logic [2:0]    idx_q, last_q;
  logic [7:0]    sh_q;
  logic          pbit_q, pen_q;
  logic [7:0]    din;
  logic          bit_end;

  assign din     = data_i & len_mask(mode_i.len);
  assign bit_end = (cnt_q == BIT_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      stop_last_q <= STOP1;
      idx_q       <= '0;
      last_q      <= '0;
      sh_q        <= '0;
      pbit_q      <= 1'b0;
      pen_q       <= 1'b0;
    end else if (ph_q == PH_IDLE) begin
      if (load_i) begin
        ph_q   <= PH_START;
        cnt_q  <= '0;
        idx_q  <= '0;
        sh_q   <= din;
        pbit_q <= par_of(din, mode_i.odd);
        pen_q  <= mode_i.par_en;
        last_q <= last_bit(mode_i.len);
        unique case (mode_i.stop)
          2'd0:    stop_last_q <= STOP1;
          2'd1:    stop_last_q <= STOP15;
          default: stop_last_q <= STOP2;
        endcase
      end
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (ph_q)
        PH_START: if (bit_end) begin
          cnt_q <= '0;
          ph_q  <= PH_DATA;
        end
        PH_DATA: if (bit_end) begin
          cnt_q <= '0;
          sh_q  <= sh_q >> 1;
          if (idx_q == last_q) ph_q <= pen_q ? PH_PAR : PH_STOP;
          else                 idx_q <= idx_q + 1'b1;
        end
        PH_PAR: if (bit_end) begin
          cnt_q <= '0;
          ph_q  <= PH_STOP;
        end
        PH_STOP: if (cnt_q == stop_last_q) begin
          cnt_q <= '0;
          ph_q  <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o = (ph_q == PH_IDLE);

  always_comb begin
    unique case (ph_q)
      PH_START: txd_o = 1'b0;
      PH_DATA:  txd_o = sh_q[0];
      PH_PAR:   txd_o = pbit_q;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       odd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] BIT_M1  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q, last_q;
  logic [7:0]    sh_q, aligned;
  logic          s1_q, s2_q, prx_q, pen_q, odd_q;
  logic          bit_end;

  assign bit_end = (cnt_q == BIT_M1);
  assign aligned = sh_q >> (3'd7 - last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= 3'd7;
      sh_q   <= '0;
      prx_q  <= 1'b0;
      pen_q  <= 1'b0;
      odd_q  <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (ph_q)
          PH_IDLE: if (!s2_q) begin
            ph_q   <= PH_START;
            cnt_q  <= '0;
            last_q <= last_bit(len_i);
            pen_q  <= par_en_i;
            odd_q  <= odd_i;
          end
          PH_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              idx_q <= '0;
              ph_q  <= s2_q ? PH_IDLE : PH_DATA;  // line back high: glitch
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              sh_q <= {s2_q, sh_q[7:1]};
              if (idx_q == last_q) ph_q <= pen_q ? PH_PAR : PH_STOP;
              else                 idx_q <= idx_q + 1'b1;
            end
          end
          PH_PAR: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              prx_q <= s2_q;
              ph_q  <= PH_STOP;
            end
          end
          PH_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
              data_o <= aligned;
              ferr_o <= !s2_q;
              perr_o <= pen_q && (prx_q != par_of(aligned, odd_q));
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_core.sv
module sio_core
  import sio_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             txd_o,
  input  logic             rxd_i,
  output logic             irq_rx_o,
  output logic             irq_tx_o
);
  logic       tick, tx_idle, rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data, rx_buf, mode_q;
  logic       rdy, pe, fe, ovr;
  logic       wr_dat, rd_dat, wr_mode;
  mode_t      mode;

  assign wr_dat  = sel_i &  wr_i & (addr_i == A_DATA);
  assign rd_dat  = sel_i & ~wr_i & (addr_i == A_DATA);
  assign wr_mode = sel_i &  wr_i & (addr_i == A_MODE);
  assign mode    = mode_t'(mode_q[5:0]);

  sio_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i, .rst_ni, .div_i, .tick_o(tick)
  );

  sio_tx #(.OVS(OVS)) i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(wr_dat), .data_i(wdata_i),
    .mode_i(mode), .idle_o(tx_idle), .txd_o(txd_o)
  );

  sio_rx #(.OVS(OVS)) i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i,
    .len_i(mode.len), .par_en_i(mode.par_en), .odd_i(mode.odd),
    .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr), .ferr_o(rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rx_buf <= '0;
      rdy    <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata_i;
      if (rx_done) begin
        rx_buf <= rx_data;
        rdy    <= 1'b1;
        pe     <= rx_perr;
        fe     <= rx_ferr;
        ovr    <= (ovr | rdy) & ~rd_dat;
      end else if (rd_dat) begin
        rdy <= 1'b0;
        pe  <= 1'b0;
        fe  <= 1'b0;
        ovr <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_DATA:  rdata_o = rx_buf;
      A_STAT:  rdata_o = {3'b000, ovr, fe, pe, tx_idle, rdy};
      A_MODE:  rdata_o = mode_q;
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_rx_o = rdy;
  assign irq_tx_o = tx_idle;
endmodule

// File: rtl/sio_core_chk.sv
module sio_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_dat_i,
  input logic rd_dat_i,
  input logic rx_done_i,
  input logic rx_rdy_i,
  input logic ovr_i,
  input logic tx_empty_i,
  input logic txd_i,
  input logic irq_rx_i
);
  assert_idle_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_i |-> txd_i);

  assert_tx_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat_i && tx_empty_i) |=> (!tx_empty_i && !txd_i));

  assert_rx_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> irq_rx_i);

  assert_overrun_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_rdy_i && !rd_dat_i) |=> ovr_i);

  assert_read_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat_i && !rx_done_i) |=> (!irq_rx_i && !ovr_i));
endmodule

bind sio_core sio_core_chk i_sio_core_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_dat_i(wr_dat), .rd_dat_i(rd_dat),
  .rx_done_i(rx_done), .rx_rdy_i(rdy), .ovr_i(ovr), .tx_empty_i(tx_idle),
  .txd_i(txd_o), .irq_rx_i(irq_rx_o)
);

// File: tb/test_sio_core.sv
`timescale 1ns/1ps
module test_sio_core;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] div_i = 16'd3;
  logic        sel_i = 1'b0, wr_i = 1'b0, rxd_i = 1'b1;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        txd_o, irq_rx_o, irq_tx_o;
  int          cyc = 0, checks = 0, fails = 0;

  localparam int BITC = 64;  // clocks per bit at div 3

  sio_core i_sio_core (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i); sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); sel_i = 0; wr_i = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); sel_i = 1; wr_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); sel_i = 0;
  endtask

  function automatic logic fpar(logic [7:0] d, int n, logic odd);
    logic p = odd;
    for (int k = 0; k < n; k++) p ^= d[k];
    return p;
  endfunction

  function automatic int stop_ticks(logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk_i);
  endtask

  // transmit one character and check frame bits and completion time (R2 R3 R4 R5)
  task automatic tx_frame(logic [7:0] d, logic [7:0] m, bit poke);
    int n = 5 + m[1:0], nb, t0, guard = 0, lows = 0, ticks;
    logic [11:0] ev = '0, gv = '0;
    logic [7:0] rb;
    bus_write(2'd2, m);
    bus_write(2'd0, d);
    for (int k = 0; k < n; k++) ev[1+k] = d[k];
    nb = 1 + n;
    if (m[2]) begin ev[nb] = fpar(d, n, m[3]); nb++; end
    ev[nb] = 1'b1;
    while (txd_o && guard < 200) begin @(negedge clk_i); guard++; end
    t0 = cyc;
    for (int j = 0; j <= nb; j++) begin
      wait_cyc(t0 + BITC * j + BITC / 2);
      gv[j] = txd_o;
      if (poke && j == 1) bus_write(2'd0, ~d);  // R5: ignored while busy
    end
    chk(m[2] ? "R2/R4 tx frame" : "R2 tx frame", 32'(gv), 32'(ev));
    ticks = 16 * nb + stop_ticks(m[5:4]);
    wait_cyc(t0 + 4 * ticks - 5);
    chk("R3 busy before stop end", 32'(irq_tx_o), 32'd0);
    wait_cyc(t0 + 4 * ticks + 1);
    chk("R3 empty after stop end", 32'(irq_tx_o), 32'd1);
    if (poke) begin
      repeat (14 * BITC) begin @(negedge clk_i); if (!txd_o) lows++; end
      chk("R5 no second frame", 32'(lows), 32'd0);
      bus_read(2'd1, rb);
      chk("R5 tx empty kept", 32'(rb[1]), 32'd1);
    end
  endtask

  task automatic drive(logic v, int n);
    rxd_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rx_frame(logic [7:0] d, logic [7:0] m, bit bad_par, bit bad_stop);
    int n = 5 + m[1:0];
    bus_write(2'd2, m);
    drive(1'b0, BITC);
    for (int k = 0; k < n; k++) drive(d[k], BITC);
    if (m[2]) drive(fpar(d, n, m[3]) ^ bad_par, BITC);
    if (bad_stop) drive(1'b0, 44);
    drive(1'b1, BITC + 16);
  endtask

  task automatic rx_expect(string tag, logic [7:0] d, bit pe, bit fe, bit ov);
    logic [7:0] rb;
    chk({tag, " irq_rx set"}, 32'(irq_rx_o), 32'd1);
    bus_read(2'd1, rb);
    chk({tag, " status"}, 32'(rb), 32'({3'b000, ov, fe, pe, 1'b1, 1'b1}));
    bus_read(2'd0, rb);
    chk({tag, " data"}, 32'(rb), 32'(d));
    chk("R11 irq_rx cleared", 32'(irq_rx_o), 32'd0);
    bus_read(2'd1, rb);
    chk("R11 status cleared", 32'(rb), 32'h02);
  endtask

  initial begin
    repeat (1950) #100;  // watchdog: 19,500 clocks x 10
    repeat (175500) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 txd idle", 32'(txd_o), 32'd1);
    chk("R1 irq_rx", 32'(irq_rx_o), 32'd0);
    chk("R1 irq_tx", 32'(irq_tx_o), 32'd1);
    bus_read(2'd1, rb); chk("R1 status", 32'(rb), 32'h02);
    bus_read(2'd0, rb); chk("R1 data", 32'(rb), 32'h00);
    // R12 mode readback
    bus_write(2'd2, 8'hE9);
    bus_read(2'd2, rb); chk("R12 mode readback", 32'(rb), 32'hE9);
    bus_read(2'd3, rb); chk("R12 unused address", 32'(rb), 32'h00);

    // directed transmit cases
    tx_frame(8'hA5, 8'h03, 1'b1);          // 8N1, busy write ignored
    tx_frame(8'h16, 8'h1C, 1'b0);          // 5 bits, odd, 1.5 stop
    tx_frame(8'h4B, 8'h26, 1'b0);          // 7 bits, even, 2 stop

    // directed receive cases
    rx_frame(8'h3C, 8'h03, 0, 0); rx_expect("R6 8N1", 8'h3C, 0, 0, 0);
    rx_frame(8'hF3, 8'h0C, 0, 0); rx_expect("R6 5 bit odd", 8'h13, 0, 0, 0);
    rx_frame(8'h5A, 8'h07, 1, 0); rx_expect("R7 parity error", 8'h5A, 1, 0, 0);
    rx_frame(8'h81, 8'h0F, 1, 0); rx_expect("R7 odd parity error", 8'h81, 1, 0, 0);
    rx_frame(8'h66, 8'h03, 0, 1); rx_expect("R8 framing error", 8'h66, 0, 1, 0);
    // R9 glitch
    drive(1'b0, 12);
    drive(1'b1, 4 * BITC);
    chk("R9 glitch no irq", 32'(irq_rx_o), 32'd0);
    bus_read(2'd1, rb); chk("R9 glitch status", 32'(rb), 32'h02);
    rx_frame(8'h29, 8'h02, 0, 0); rx_expect("R9 frame after glitch", 8'h29, 0, 0, 0);
    // R10 overrun
    rx_frame(8'h11, 8'h03, 0, 0);
    rx_frame(8'hC4, 8'h03, 0, 0);
    rx_expect("R10 overrun", 8'hC4, 0, 0, 1);

    // constrained random
    for (int it = 0; it < 10; it++) begin
      logic [7:0] d, m, msk;
      d   = 8'($urandom);
      m   = {2'b00, 2'($urandom_range(0, 2)), 4'($urandom)};
      msk = 8'hFF >> (3 - m[1:0]);
      tx_frame(d, m, 1'b0);
      rx_frame(d, m, 0, 0);
      rx_expect("R6 random", d & msk, 0, 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule